// File: doc/BRIEF.md
# Four-Way Tag Directory with Rotating Fill Pointer

This block holds the tags and valid bits for a small set-associative cache whose blocks carry a single word each. Every cycle it may receive one lookup request that carries a word address. The low address bits choose a set. The remaining bits form the tag, which is compared against every way of that set at once. One clock later the block reports whether the word was present, which set was used and which way holds the word.

When a lookup misses, the block always installs the word in the selected set. Each set keeps its own rotating fill pointer, and that pointer moves only on a miss. Ways therefore fill as 0, 1, 2, 3 and then wrap back to 0, whatever the order of recent hits. The result is first-in first-out replacement rather than least-recently-used. A synchronous flush empties the whole directory.

The design is split into three parts under a thin top:
- a datapath that holds the tag storage, the comparators and the response registers;
- a control part that holds the per-set pointers;
- a small strobe struct that carries control decisions from the control part to the datapath.

Top module: `tagdir_top`

## Requirements
- R1: After reset, and after a flush, every way is invalid, so the first lookup of any address misses.
- R2: A request accepted at a clock edge (reqValid high, flush low) produces respValid high for exactly the following cycle. In a cycle with no accepted request, respValid is low in the next cycle.
- R3: The set used is the address modulo the set count, taken from the two low address bits, and it is reported on respSet.
- R4: A lookup hits when any valid way of the selected set holds a tag equal to the address bits above the set index. respWay then gives that way, encoded 0..3 for the first to the fourth way.
- R5: On a miss the word is written into the way chosen by the set's pointer. The first miss after the set is emptied uses way 0. Each later miss uses the way after the previous fill, wrapping from way 3 to way 0. respWay reports the filled way.
- R6: A hit does not move the set's pointer, so a later miss replaces the way after the last filled one, even when that way was hit recently.
- R7: A word allocated by one request is visible to a request presented in the very next cycle.
- R8: A flush clears all valid bits and all pointers at the clock edge. A request presented together with flush is dropped: it gives no response and allocates nothing.
- R9: Sets are independent: misses in one set never change the contents or the fill order of another set.
- R10: The full upper address bits form the tag, so two addresses in the same set that differ in any upper bit never alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all valid bits and pointers |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | ADDR_W (8) | Word address of the lookup |
| respValid | output | 1 | Response strobe, one cycle after an accepted request |
| respHit | output | 1 | 1 = word was present, 0 = miss (word now allocated) |
| respSet | output | SET_W (2) | Set used by the request |
| respWay | output | WAY_W (2) | Way that held or received the word |

## Verification
Every response field is registered once and is due exactly one clock after its request. Allocation and pointer movement take effect at that same edge, so a request in the next cycle already sees them. The bench drives each request on a falling edge and samples all four response fields on the following falling edge, after the single registering edge. Back-to-back requests are checked the same way, one edge apart. A flush is checked by the absence of a response in the cycle after it, followed by a miss on way 0.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  // Strobes passed from the control part to the datapath for one cycle.
  typedef struct packed {
    logic doResp;   // register a response for the current request
    logic doFill;   // write the current request into fillWay
    logic doFlush;  // clear every valid bit
  } dirStrobe_t;

endpackage

// File: rtl/tagdir_datapath.sv
module tagdir_datapath
  import tagdir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dirStrobe_t        ctl,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [SET_W-1:0]  lookSet,
  output logic              lookHit,
  output logic              respValid,
  output logic              respHit,
  output logic [SET_W-1:0]  respSet,
  output logic [WAY_W-1:0]  respWay
);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;

  assign lookSet = reqAddr[SET_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:SET_W];

  // One comparator per way of the selected set.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[lookSet][w] && (tagMem[lookSet][w] == reqTag);
  end

  assign lookHit = |hitVec;

  // Way encoder; at most one way can match.
  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // Valid bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctl.doFlush) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (ctl.doFill) begin
      validMem[lookSet][fillWay] <= 1'b1;
    end
  end

  // Tag storage; no reset needed, guarded by the valid bits.
  always_ff @(posedge clk) begin
    if (ctl.doFill) tagMem[lookSet][fillWay] <= reqTag;
  end

  // Response registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respSet   <= '0;
      respWay   <= '0;
    end else begin
      respValid <= ctl.doResp;
      if (ctl.doResp) begin
        respHit <= lookHit;
        respSet <= lookSet;
        respWay <= lookHit ? hitWay : fillWay;
      end
    end
  end

endmodule

// File: rtl/tagdir_control.sv
module tagdir_control
  import tagdir_pkg::*;
#(
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             reqValid,
  input  logic [SET_W-1:0] lookSet,
  input  logic             lookHit,
  output dirStrobe_t       ctl,
  output logic [WAY_W-1:0] fillWay
);

  logic [WAY_W-1:0] ptrReg [SETS];
  logic [SETS-1:0]  ptrNone;
  logic [WAY_W-1:0] curPtr;

  assign curPtr = ptrReg[lookSet];

  // Next fill position: way 0 from the empty state, else one past the last fill.
  always_comb begin
    if (ptrNone[lookSet])                   fillWay = '0;
    else if (curPtr == WAY_W'(WAYS - 1))    fillWay = '0;
    else                                    fillWay = curPtr + 1'b1;
  end

  always_comb begin
    ctl.doFlush = flush;
    ctl.doResp  = reqValid && !flush;
    ctl.doFill  = reqValid && !flush && !lookHit;
  end

  // Per-set pointer; moves on fills only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrNone <= '1;
      for (int s = 0; s < SETS; s++) ptrReg[s] <= '0;
    end else if (ctl.doFlush) begin
      ptrNone <= '1;
      for (int s = 0; s < SETS; s++) ptrReg[s] <= '0;
    end else if (ctl.doFill) begin
      ptrReg[lookSet]  <= fillWay;
      ptrNone[lookSet] <= 1'b0;
    end
  end

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 4,   // power of two, at least 2
  parameter int unsigned WAYS   = 4,   // power of two, at least 2
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [SET_W-1:0]  respSet,
  output logic [WAY_W-1:0]  respWay
);

  dirStrobe_t       ctl;
  logic [WAY_W-1:0] fillWay;
  logic [SET_W-1:0] lookSet;
  logic             lookHit;

  tagdir_control #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .reqValid(reqValid),
    .lookSet(lookSet), .lookHit(lookHit), .ctl(ctl), .fillWay(fillWay)
  );

  tagdir_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .fillWay(fillWay), .reqAddr(reqAddr),
    .lookSet(lookSet), .lookHit(lookHit), .respValid(respValid),
    .respHit(respHit), .respSet(respSet), .respWay(respWay)
  );

endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              respValid,
  input logic              respHit,
  input logic [SET_W-1:0]  respSet,
  input logic [WAY_W-1:0]  respWay
);

  logic             accepted;
  logic [WAY_W-1:0] wayInc;
  assign accepted = reqValid && !flush;
  assign wayInc   = respWay + 1'b1;

  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> respValid); // R2

  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> !respValid); // R2

  AST_SET_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (respSet == $past(reqAddr[SET_W-1:0]))); // R3

  AST_REPEAT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    accepted ##1 (accepted && $stable(reqAddr)) |=> respHit); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 accepted |=> !respHit); // R8

  AST_MISS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respHit) ##1 (respValid && !respHit && respSet == $past(respSet))
      |-> respWay == $past(wayInc)); // R5

endmodule

bind tagdir_top tagdir_chk #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .reqValid(reqValid), .reqAddr(reqAddr),
  .respValid(respValid), .respHit(respHit), .respSet(respSet), .respWay(respWay)
);

// File: tb/sim_tagdir_top.sv
`timescale 1ns/1ps
module sim_tagdir_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqAddr = '0;
  logic       respValid, respHit;
  logic [1:0] respSet, respWay;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // Bench model of the directory, built from the requirements.
  int mTag [4][4];
  bit mValid [4][4];
  int mPtr [4];
  bit mNone [4];

  always #2 clk = ~clk;

  tagdir_top u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .reqValid(reqValid), .reqAddr(reqAddr),
    .respValid(respValid), .respHit(respHit), .respSet(respSet), .respWay(respWay)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int s = 0; s < 4; s++) begin
      mNone[s] = 1'b1;
      mPtr[s] = 0;
      for (int w = 0; w < 4; w++) mValid[s][w] = 1'b0;
    end
  endtask

  // Issue one request at a falling edge; check its response on the next one.
  task automatic access(input logic [7:0] a, input string rq);
    int s, tg, ew;
    bit eh;
    s = int'(a) % 4;
    tg = int'(a) / 4;
    eh = 1'b0;
    ew = 0;
    for (int w = 0; w < 4; w++)
      if (mValid[s][w] && mTag[s][w] == tg) begin eh = 1'b1; ew = w; end
    if (!eh) begin
      ew = mNone[s] ? 0 : (mPtr[s] + 1) % 4;
      mPtr[s] = ew;
      mNone[s] = 1'b0;
      mValid[s][ew] = 1'b1;
      mTag[s][ew] = tg;
    end
    reqValid = 1'b1;
    reqAddr = a;
    @(negedge clk);
    chk(respValid == 1'b1, {rq, " R2 respValid"}, int'(respValid), 1);
    chk(respSet == 2'(s), {rq, " R3 respSet"}, int'(respSet), s);
    chk(respHit == eh, {rq, " R4 respHit"}, int'(respHit), int'(eh));
    chk(respWay == 2'(ew), {rq, " R5 respWay"}, int'(respWay), ew);
    reqValid = 1'b0;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    modelClear();
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin : main
    int seq [19] = '{1, 4, 8, 5, 20, 17, 19, 56, 9, 11, 4, 43, 5, 6, 9, 17, 9, 56, 9};
    bit expHit [19] = '{0,0,0,0,0,0,0,0,0,0, 1,0,1,0,1,1,1,1,1};
    logic [15:0] lfsr;
    modelClear();
    repeat (3) @(negedge clk);
    chk(respValid == 1'b0, "R2 reset respValid", int'(respValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(respValid == 1'b0, "R2 idle respValid", int'(respValid), 0);

    // Worked address sequence; R1 first lookups miss.
    for (int i = 0; i < 19; i++) begin
      access(8'(seq[i]), "R1 seq");
      chk(respHit == expHit[i], "R4 seq hit list", int'(respHit), int'(expHit[i]));
      if (seq[i] == 43) chk(respSet == 2'd3 && respWay == 2'd2, "R5 word 43 way", int'(respWay), 2);
      if (i == 13) chk(respSet == 2'd2 && respWay == 2'd0, "R5 word 6 way", int'(respWay), 0);
    end

    // R6: hits do not move the pointer.
    doFlush();
    access(8'd0, "R1 after flush");
    chk(respHit == 1'b0, "R1 flush miss", int'(respHit), 0);
    access(8'd4, "R5 fill");
    access(8'd8, "R5 fill");
    access(8'd12, "R5 fill");
    repeat (3) access(8'd4, "R6 hit");
    access(8'd16, "R6 wrap");
    chk(respWay == 2'd0, "R6 wrap way", int'(respWay), 0);
    access(8'd20, "R6 next");
    chk(respWay == 2'd1, "R6 recently hit way replaced", int'(respWay), 1);
    access(8'd4, "R6 evicted");
    chk(respHit == 1'b0, "R6 evicted word misses", int'(respHit), 0);

    // R7: back-to-back reuse of a new word.
    access(8'd77, "R7 first");
    access(8'd77, "R7 second");
    chk(respHit == 1'b1, "R7 back-to-back hit", int'(respHit), 1);

    // R8: a request together with flush is dropped.
    reqValid = 1'b1; reqAddr = 8'd77; flush = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; flush = 1'b0;
    modelClear();
    chk(respValid == 1'b0, "R8 dropped request", int'(respValid), 0);
    access(8'd77, "R8 after flush");
    chk(respHit == 1'b0 && respWay == 2'd0, "R8 not allocated", int'(respHit), 0);

    // R9: other sets untouched by traffic in set 1.
    access(8'd2, "R9 set2");
    for (int k = 0; k < 9; k++) access(8'(4 * k + 1), "R9 set1");
    access(8'd2, "R9 set2 again");
    chk(respHit == 1'b1 && respWay == 2'd0, "R9 set2 kept", int'(respWay), 0);

    // R10: upper bits distinguish tags.
    access(8'h03, "R10 low");
    access(8'h83, "R10 high");
    chk(respHit == 1'b0, "R10 no alias", int'(respHit), 0);

    // Sweeps against the model: small address space, then full byte.
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(8'(lfsr[4:0]), "R9 sweep");
      if (i % 500 == 499) doFlush();
    end
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[7:0], "R10 sweep");
    end

    @(negedge clk);
    chk(respValid == 1'b0, "R2 final idle", int'(respValid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule